// File: doc/BRIEF.md
# Address Tenure Master with Snoop Capture

This block runs the address phase of a split-transaction processor bus that carries a 32-bit address. A local client hands it a transfer through a one-cycle accept handshake: an address and a flag that says whether the transfer is a burst. The block then raises a bus request and waits for a qualified grant. A grant is qualified when the block has its request pending and no other agent holds address-busy in that cycle.

In the cycle after a qualified grant, the block drives the address onto the bus and enables its address outputs. In that same cycle it pulses the transfer-start strobe for one cycle and raises address-busy. It holds all of these until address acknowledge arrives. One cycle after the acknowledge it releases the bus. Tri-state drive is modelled by an output-enable signal.

For a burst, the block presents the double-word-aligned critical address and never increments it. When the block is not mastering, it watches transfer-start from other agents. It latches the bus address only in that strobe cycle and reports it with a one-cycle valid pulse.

Top module: `addr_tenure_master`

## Requirements
- R1: After reset, req_ready_o is 1. bus_req_o, addr_oe_o, ts_o, abusy_o and snoop_valid_o are all 0, and addr_o reads 0.
- R2: A request accepted while req_ready_o is 1 makes bus_req_o rise in the next cycle. bus_req_o stays high up to and including the cycle of the qualified grant, and is low after it.
- R3: A grant counts only when bus_grant_i is 1 and abusy_i is 0 while bus_req_o is 1. A grant seen while abusy_i is 1 starts no drive.
- R4: In the cycle after a qualified grant, addr_oe_o, abusy_o and ts_o are all 1, and addr_o carries the transfer address.
- R5: ts_o is high for exactly one cycle per tenure, namely the first drive cycle.
- R6: addr_oe_o and abusy_o stay high, with addr_o unchanged, through the cycle in which aack_i is 1. Both are 0 in the following cycle, and addr_o then reads 0.
- R7: For a burst (req_burst_i = 1), bits [2:0] of the driven address are 0 and the upper bits are those requested. For a single beat, the full requested address is driven. The address is never incremented during the tenure.
- R8: When ts_i is 1 while abusy_o is 0, snoop_valid_o is 1 in the next cycle only, and snoop_addr_o equals the addr_i value of the strobe cycle. addr_i in any other cycle has no effect.
- R9: ts_i seen while abusy_o is 1 produces no snoop_valid_o pulse.
- R10: req_ready_o is 1 only when the block is idle. req_valid_i presented while req_ready_o is 0 is ignored and does not change the address later driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Client offers a transfer |
| req_addr_i | input | 32 | Transfer address |
| req_burst_i | input | 1 | 1 = burst, 0 = single beat |
| req_ready_o | output | 1 | Block idle, offer accepted |
| bus_req_o | output | 1 | Bus request to arbiter |
| bus_grant_i | input | 1 | Bus grant from arbiter |
| abusy_i | input | 1 | Address-busy held by another agent |
| aack_i | input | 1 | Address acknowledge |
| ts_i | input | 1 | Transfer start from another agent |
| addr_i | input | 32 | Bus address as seen on input |
| addr_o | output | 32 | Driven address (0 when not enabled) |
| addr_oe_o | output | 1 | Address output enable |
| ts_o | output | 1 | Transfer-start strobe |
| abusy_o | output | 1 | Own address-busy |
| snoop_valid_o | output | 1 | Snoop address captured, one-cycle pulse |
| snoop_addr_o | output | 32 | Captured snoop address |

## Verification
The hardest situations to reach are overlaps of events. One is a grant that arrives while another agent still holds address-busy. Another is an acknowledge that lands in the same cycle as the transfer-start strobe. A third is a foreign transfer-start that arrives while the block is itself driving. Directed phases force each of these edges explicitly. A long stretch of random grant, busy, acknowledge and snoop traffic then lets a behavioural model, compared on every cycle, catch overlaps that were not planned.

// File: rtl/atm_pkg.sv
package atm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_TS   = 2'd2,
    ST_HOLD = 2'd3
  } atm_state_e;
endpackage

// File: rtl/atm_addr_fmt.sv
module atm_addr_fmt #(
  parameter int AW       = 32,
  parameter int LOW_BITS = 3
) (
  input  logic [AW-1:0] addr_i,
  input  logic          burst_i,
  output logic [AW-1:0] addr_o
);
  localparam int HI = AW - LOW_BITS;

  generate
    if (LOW_BITS == 0) begin : g_none
      assign addr_o = addr_i;
    end else begin : g_mask
      assign addr_o = burst_i ? {addr_i[AW-1:LOW_BITS], {LOW_BITS{1'b0}}} : addr_i;
    end
  endgenerate

  initial begin
    if (HI < 1) $error("atm_addr_fmt: LOW_BITS too large");
  end
endmodule

// File: rtl/atm_ctrl.sv
module atm_ctrl
  import atm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          req_ready_o,
  output logic          bus_req_o,
  input  logic          bus_grant_i,
  input  logic          abusy_i,
  input  logic          aack_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe_o,
  output logic          ts_o,
  output logic          abusy_o
);
  atm_state_e state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          grant_ok;

  assign grant_ok = bus_grant_i && !abusy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_REQ;
      ST_REQ:  if (grant_ok)    state_d = ST_TS;
      ST_TS:   state_d = aack_i ? ST_IDLE : ST_HOLD;
      ST_HOLD: if (aack_i)      state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) addr_q <= req_addr_i;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign bus_req_o   = (state_q == ST_REQ);
  assign ts_o        = (state_q == ST_TS);
  assign abusy_o     = (state_q == ST_TS) || (state_q == ST_HOLD);
  assign addr_oe_o   = abusy_o;
  assign addr_o      = addr_oe_o ? addr_q : '0;

  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !(bus_grant_i && !abusy_i)) |=> bus_req_o);
  a_r4_drive_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_grant_i && !abusy_i) |=> (ts_o && addr_oe_o && abusy_o));
  a_r5_ts_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_o |=> !ts_o);
  a_r6_release_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abusy_o && aack_i) |=> (!addr_oe_o && !abusy_o));
  a_r7_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abusy_o && !ts_o) |-> $stable(addr_o));
endmodule

// File: rtl/atm_snoop.sv
module atm_snoop #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ts_i,
  input  logic [AW-1:0] addr_i,
  input  logic          mastering_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= ts_i && !mastering_i;
      if (ts_i && !mastering_i) addr_o <= addr_i;
    end
  end

  a_r8_snoop_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_i && !mastering_i) |=> (valid_o && addr_o == $past(addr_i)));
  a_r9_snoop_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_i && mastering_i) |=> !valid_o);
endmodule

// File: rtl/addr_tenure_master.sv
module addr_tenure_master #(
  parameter int AW       = 32,
  parameter int LOW_BITS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_burst_i,
  output logic          req_ready_o,
  output logic          bus_req_o,
  input  logic          bus_grant_i,
  input  logic          abusy_i,
  input  logic          aack_i,
  input  logic          ts_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe_o,
  output logic          ts_o,
  output logic          abusy_o,
  output logic          snoop_valid_o,
  output logic [AW-1:0] snoop_addr_o
);
  logic [AW-1:0] fmt_addr;

  atm_addr_fmt #(.AW(AW), .LOW_BITS(LOW_BITS)) u_fmt (
    .addr_i  (req_addr_i),
    .burst_i (req_burst_i),
    .addr_o  (fmt_addr)
  );

  atm_ctrl #(.AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (fmt_addr),
    .req_ready_o (req_ready_o),
    .bus_req_o   (bus_req_o),
    .bus_grant_i (bus_grant_i),
    .abusy_i     (abusy_i),
    .aack_i      (aack_i),
    .addr_o      (addr_o),
    .addr_oe_o   (addr_oe_o),
    .ts_o        (ts_o),
    .abusy_o     (abusy_o)
  );

  atm_snoop #(.AW(AW)) u_snoop (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ts_i        (ts_i),
    .addr_i      (addr_i),
    .mastering_i (abusy_o),
    .valid_o     (snoop_valid_o),
    .addr_o      (snoop_addr_o)
  );

  a_r10_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!bus_req_o && !abusy_o));
endmodule

// File: tb/addr_tenure_master_test.sv
`timescale 1ns/1ps
module addr_tenure_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_burst = 1'b0;
  logic [31:0] req_addr = '0;
  logic        bus_grant = 1'b0, abusy_in = 1'b0, aack = 1'b0, ts_in = 1'b0;
  logic [31:0] addr_in = '0;
  logic        req_ready, bus_req, addr_oe, ts_out, abusy_out, snp_v;
  logic [31:0] addr_out, snp_a;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference model state
  int          m_phase = 0;   // 0 idle, 1 requesting, 2 driving
  bit          m_first = 0;
  logic [31:0] m_addr = '0;
  bit          m_snp_v = 0;
  logic [31:0] m_snp_a = '0;

  always #2 clk = ~clk;

  addr_tenure_master uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_burst_i(req_burst),
    .req_ready_o(req_ready), .bus_req_o(bus_req), .bus_grant_i(bus_grant),
    .abusy_i(abusy_in), .aack_i(aack), .ts_i(ts_in), .addr_i(addr_in),
    .addr_o(addr_out), .addr_oe_o(addr_oe), .ts_o(ts_out), .abusy_o(abusy_out),
    .snoop_valid_o(snp_v), .snoop_addr_o(snp_a)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // model update on each edge with the inputs held across it
  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      m_snp_v = ts_in && (m_phase != 2);
      if (m_snp_v) m_snp_a = addr_in;
      case (m_phase)
        0: if (req_valid) begin
             m_addr  = req_burst ? (req_addr & ~32'h7) : req_addr;
             m_phase = 1;
           end
        1: if (bus_grant && !abusy_in) begin
             m_phase = 2;
             m_first = 1;
           end
        default: begin
          m_first = 0;
          if (aack) m_phase = 0;
        end
      endcase
    end
  end

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(req_ready == (m_phase == 0), "R10 req_ready", 32'(req_ready), 32'(m_phase == 0));
      chk(bus_req == (m_phase == 1), "R2 bus_req", 32'(bus_req), 32'(m_phase == 1));
      chk(abusy_out == (m_phase == 2), "R4 abusy", 32'(abusy_out), 32'(m_phase == 2));
      chk(addr_oe == (m_phase == 2), "R6 addr_oe", 32'(addr_oe), 32'(m_phase == 2));
      chk(ts_out == (m_phase == 2 && m_first), "R5 ts", 32'(ts_out), 32'(m_phase == 2 && m_first));
      chk(addr_out == ((m_phase == 2) ? m_addr : 32'h0), "R7 addr", addr_out,
          (m_phase == 2) ? m_addr : 32'h0);
      chk(snp_v == m_snp_v, "R9 snoop_valid", 32'(snp_v), 32'(m_snp_v));
      if (m_snp_v) chk(snp_a == m_snp_a, "R8 snoop_addr", snp_a, m_snp_a);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_inputs();
    req_valid = 0; bus_grant = 0; abusy_in = 0; aack = 0; ts_in = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'(cycles), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    cyc(3);
    // R1 reset state
    chk(req_ready && !bus_req && !addr_oe && !ts_out && !abusy_out && !snp_v && addr_out == 0,
        "R1 reset outputs", {26'd0, req_ready, bus_req, addr_oe, ts_out, abusy_out, snp_v}, 32'h20);
    rst_n = 1;
    cyc(2);

    // single beat, grant first seen while abusy_i held (R3), long hold
    req_valid = 1; req_addr = 32'h1234_5677; req_burst = 0;
    cyc(1); idle_inputs(); req_addr = 32'hFFFF_FFFF;
    chk(bus_req, "R2 request raised", 32'(bus_req), 32'd1);
    bus_grant = 1; abusy_in = 1;
    cyc(1);
    chk(!ts_out && bus_req, "R3 unqualified grant ignored", 32'(ts_out), 32'd0);
    abusy_in = 0;
    req_valid = 1; req_addr = 32'hDEAD_0000; // R10: ignored while busy
    cyc(1); bus_grant = 0; req_valid = 0;
    chk(ts_out && addr_out == 32'h1234_5677, "R4 drive after grant", addr_out, 32'h1234_5677);
    cyc(3);
    ts_in = 1; addr_in = 32'h0BAD_F00D; // R9 snoop while mastering
    cyc(1); ts_in = 0; aack = 1;
    chk(!snp_v, "R9 suppressed", 32'(snp_v), 32'd0);
    cyc(1); aack = 0;
    chk(!addr_oe && addr_out == 0, "R6 released", 32'(addr_oe), 32'd0);

    // burst, acknowledge in the strobe cycle
    req_valid = 1; req_addr = 32'hABCD_EF0D; req_burst = 1;
    cyc(1); req_valid = 0; bus_grant = 1;
    cyc(1); bus_grant = 0; aack = 1;
    chk(ts_out && addr_out == 32'hABCD_EF08, "R7 burst aligned", addr_out, 32'hABCD_EF08);
    cyc(1); aack = 0;
    chk(!abusy_out && !ts_out, "R6 ack on ts cycle", 32'(abusy_out), 32'd0);

    // snoop capture while idle, address changes afterwards
    addr_in = 32'h5555_AAAA; ts_in = 1;
    cyc(1); ts_in = 0; addr_in = 32'h1111_1111;
    chk(snp_v && snp_a == 32'h5555_AAAA, "R8 captured", snp_a, 32'h5555_AAAA);
    cyc(1);
    chk(!snp_v, "R8 single pulse", 32'(snp_v), 32'd0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      req_valid = $urandom_range(0, 3) == 0;
      req_addr  = $urandom;
      req_burst = $urandom_range(0, 1);
      bus_grant = $urandom_range(0, 1);
      abusy_in  = $urandom_range(0, 2) == 0;
      aack      = $urandom_range(0, 3) == 0;
      ts_in     = $urandom_range(0, 4) == 0;
      addr_in   = $urandom;
      cyc(1);
    end
    idle_inputs();
    cyc(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule